// File: doc/BRIEF.md
# Programmable Interval Down-Timer

This block times intervals for a controller state machine. It keeps two programmable interval values, one for a long interval and one for a short interval. A user write port stores a 6-bit value into either of them, with a select input choosing which one. When the controller asks for a load, it picks one of the two intervals. That value goes into the top six bits of a 16-bit down counter, and the ten bits below are cleared. One unit of a programmed interval is therefore 1024 clock cycles.

After a load the counter drops by one on every clock. When it reaches zero it raises `done`. It then stays at zero, and `done` stays high, until the controller loads it again. The count is never cleared apart from reset. It changes only through a load or a decrement. The current count is also brought out so that a controller can watch the remaining time.

Top module: `prog_interval_timer`

## Requirements
- R1: In the cycle after a synchronous reset (`rst_n` low at a rising edge), `count` is 0, `done` is 1, and both interval registers hold 0.
- R2: A write (`wr_en`=1) stores `wr_data` into the long interval register when `wr_sel`=0 and into the short interval register when `wr_sel`=1. The stored value is what a later load of that register uses.
- R3: A load (`ld_en`=1) sets `count` to the chosen interval value in bits 15:10 with bits 9:0 zero. `ld_sel`=0 chooses the long register and `ld_sel`=1 chooses the short one. The new count is visible in the cycle after the load edge.
- R4: When `ld_en`=0 and `count` is not zero, `count` drops by exactly one at each rising edge.
- R5: `done` is 1 exactly when `count` is 0.
- R6: When `count` is 0 and `ld_en`=0, `count` stays 0 and `done` stays 1 for every later cycle until a load.
- R7: A load in a cycle where the counter would otherwise decrement takes priority: the count becomes the loaded value, not the decremented one.
- R8: If a write and a load address the same register in the same cycle, the counter takes the value that register held before the write. The new value takes effect from the next load.
- R9: Loading an interval value of 0 makes `done` read 1 in the cycle right after the load edge.
- R10: A write to one interval register leaves the other register's value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store `wr_data` into the register picked by `wr_sel` |
| wr_sel | input | 1 | Write target: 0 long, 1 short |
| wr_data | input | 6 | Interval value to store |
| ld_en | input | 1 | Load the counter from the register picked by `ld_sel` |
| ld_sel | input | 1 | Load source: 0 long, 1 short |
| count | output | 16 | Current counter value |
| done | output | 1 | High while the counter is zero |

## Verification
The bench loads a full countdown from a small short interval and lets it run down to zero. This separates a correct decrement and hold-at-zero from an off-by-one or a wrap below zero. It then runs a long interval of the maximum value, which shows whether the upper-bit placement and lower-bit clearing are right, since any error there shifts the run length by whole units. Reloads during a countdown, a write and a load to the same register in one cycle, and a load of zero each tell the priority rules apart from a design that decrements first, loads the freshly written value, or raises `done` late. Writes to one register followed by a load of the other show whether the register select is decoded correctly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int IVL_W = 6;
  localparam int CNT_W = 16;
  localparam int N_IVL = 2;

  typedef enum logic {SEL_LONG = 1'b0, SEL_SHORT = 1'b1} ivl_sel_e;

  // place an interval value into the top bits of the count, low bits cleared
  function automatic logic [CNT_W-1:0] scale_ivl(input logic [IVL_W-1:0] v);
    return {v, {(CNT_W-IVL_W){1'b0}}};
  endfunction

  // one step of the down counter: hold at zero, else minus one
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction
endpackage

// File: rtl/ivl_bank.sv
module ivl_bank #(
  parameter int W = tmr_pkg::IVL_W,
  parameter int N = tmr_pkg::N_IVL,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic [SW-1:0] rd_sel,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] regs [N];
  logic [N-1:0] wr_hit;

  for (genvar g = 0; g < N; g++) begin : g_reg
    assign wr_hit[g] = wr_en && (wr_sel == SW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)      regs[g] <= '0;
      else if (wr_hit[g]) regs[g] <= wr_data;
    end
    // R10: a register not addressed by the write keeps its value
    p_untouched_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[g] |=> $stable(regs[g]));
    // R2: the addressed register takes the written data
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[g] |=> regs[g] == $past(wr_data));
  end

  assign rd_data = regs[rd_sel];

  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
endmodule

// File: rtl/down_cnt.sv
module down_cnt #(
  parameter int CW = tmr_pkg::CNT_W,
  parameter int IW = tmr_pkg::IVL_W,
  localparam int LOW_W = CW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_val,
  output logic [CW-1:0] count,
  output logic          at_zero
);
  import tmr_pkg::*;

  logic [CW-1:0] cnt_q;
  logic          dec_ev;

  assign dec_ev = !ld_en && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (ld_en) cnt_q <= scale_ivl(ld_val);
    else            cnt_q <= step_down(cnt_q);
  end

  assign count   = cnt_q;
  assign at_zero = (cnt_q == '0);

  // R3: low bits cleared and top bits equal to the loaded value
  p_load_place_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (cnt_q[LOW_W-1:0] == '0) && (cnt_q[CW-1:LOW_W] == $past(ld_val)));
  // R4: minus one per clock
  p_dec_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ev |=> cnt_q == $past(cnt_q) - 1'b1);
  // R6: rests at zero until a load
  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !ld_en) |=> at_zero);
  // R9: loading zero gives done right away
  p_zero_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_val == '0) |=> at_zero);
endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [5:0]  wr_data,
  input  logic        ld_en,
  input  logic        ld_sel,
  output logic [15:0] count,
  output logic        done
);
  import tmr_pkg::*;

  logic [IVL_W-1:0] sel_ivl;

  ivl_bank #(.W(IVL_W), .N(N_IVL)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (ld_sel),
    .rd_data (sel_ivl)
  );

  down_cnt #(.CW(CNT_W), .IW(IVL_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_val  (sel_ivl),
    .count   (count),
    .at_zero (done)
  );

  // R8: same-register write and load uses the old value
  p_old_on_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && wr_en && (wr_sel == ld_sel)) |=> count[15:10] == $past(sel_ivl));
  // R7: load wins over decrement
  p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && count != '0) |=> count[9:0] == '0);
endmodule

// File: tb/test_prog_interval_timer.sv
module test_prog_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, ld_en = 1'b0, ld_sel = 1'b0;
  logic [5:0]  wr_data = '0;
  logic [15:0] count;
  logic        done;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  int m_long = 0, m_short = 0, m_cnt = 0;

  always #2 clk = ~clk;

  prog_interval_timer i_prog_interval_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ld_en(ld_en), .ld_sel(ld_sel), .count(count), .done(done));

  // behavioural reference, load reads the value before any write of this edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_long = 0; m_short = 0;
    end else begin
      if (ld_en) m_cnt = (ld_sel ? m_short : m_long) * 1024;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (wr_en) begin
        if (wr_sel) m_short = wr_data; else m_long = wr_data;
      end
    end
  end

  // compare on every cycle, away from the rising edge
  always @(negedge clk) begin
    cycles++;
    checks++;
    if (count !== 16'(m_cnt) || done !== (m_cnt == 0)) begin
      errors++;
      $display("FAIL %s: count=%0d done=%0b expected count=%0d done=%0b",
               cur_req, count, done, m_cnt, (m_cnt == 0));
    end
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 200000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic s, logic [5:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ld(logic s);
    ld_en = 1'b1; ld_sel = s;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic expect_val(string r, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", r, got, exp);
    end
  endtask

  initial begin
    cur_req = "R1"; tick(3); rst_n = 1'b1; tick(1);
    expect_val("R1", int'(count), 0);
    expect_val("R1", int'(done), 1);
    ld(1'b0); expect_val("R1", int'(count), 0); // long register reset to 0

    cur_req = "R2"; wr(1'b1, 6'd1); wr(1'b0, 6'd3);
    cur_req = "R3"; ld(1'b1); expect_val("R3", int'(count), 1024);
    cur_req = "R4"; tick(500); expect_val("R4", int'(count), 524);
    cur_req = "R5"; tick(523); expect_val("R5", int'(done), 0);
    tick(1); expect_val("R5", int'(done), 1);
    cur_req = "R6"; tick(50); expect_val("R6", int'(count), 0);

    cur_req = "R3"; ld(1'b0); expect_val("R3", int'(count), 3072);
    cur_req = "R7"; tick(10); ld(1'b1); expect_val("R7", int'(count), 1024);

    cur_req = "R8";
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 6'd5; ld_en = 1'b1; ld_sel = 1'b1;
    @(negedge clk); wr_en = 1'b0; ld_en = 1'b0;
    expect_val("R8", int'(count), 1024);
    ld(1'b1); expect_val("R8", int'(count), 5120);

    cur_req = "R10"; wr(1'b0, 6'd0); ld(1'b1); expect_val("R10", int'(count), 5120);
    cur_req = "R9"; ld(1'b0); expect_val("R9", int'(done), 1);
    tick(3);

    cur_req = "R4"; wr(1'b0, 6'd63); ld(1'b0);
    expect_val("R4", int'(count), 64512);
    tick(64511); expect_val("R4", int'(count), 1);
    tick(1); expect_val("R6", int'(done), 1);
    cur_req = "R6"; tick(20);

    cur_req = "R1"; rst_n = 1'b0; tick(2); rst_n = 1'b1; ld(1'b1);
    expect_val("R1", int'(count), 0);
    tick(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule